// File: doc/BRIEF.md
# SPI Memory Command and Status Controller

This block is the serial front end of a small byte-addressed nonvolatile store. A host talks to it over a four-wire SPI link in mode 0. Each selection, which is a low period of chip select, carries one 8-bit opcode and then any address and data bytes that opcode needs. The block decodes the opcode and keeps an 8-bit status byte. That byte holds a write-protect enable, a volatile spare field, two block-protect bits, a write enable latch and a write-busy flag. The block returns status, memory or identification bytes on MISO.

Memory and status writes are guarded in three ways: by the write enable latch, by the block-protect code, and by an external write-protect input. Every accepted write is followed by a timed busy phase. During that phase the host polls the status byte until the busy flag drops. An internal register array stands in for the storage cells, so the block can be exercised on its own. Two opcodes put the controller to sleep. While asleep it ignores traffic until the next selection wakes it.

The link is oversampled by the system clock. SCK must therefore be slower than a quarter of the clock rate, and the write-protect input is treated as quasi-static.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: The link runs in SPI mode 0. MOSI is taken on SCK rising edges and MISO changes after falling edges, most significant bit first. Opcode 0x05 returns the status byte. Bit 7 is the protect enable, bits 6:4 are the spare field, bits 3:2 are the block-protect code, bit 1 is the write enable latch (WEL) and bit 0 is write-busy (WIP). The status byte is sent again for every further byte clocked in the same selection.
- R2: After reset the status byte reads 0x00.
- R3: Opcode 0x06 sets WEL and opcode 0x04 clears it. In both cases the change takes effect at the chip-select rising edge that ends the command.
- R4: Opcode 0x01 followed by one data byte loads bits 7:2 of the status byte from that data byte. Bits 1:0 of the data byte are ignored.
- R5: Opcodes 0x02 and 0x01 do nothing when WEL is 0. No memory cell or status bit changes and no busy phase starts.
- R6: An accepted memory or status write starts a busy phase at the chip-select rising edge. WIP stays 1 for WRITE_CYCLES clock cycles, and WEL is cleared when the phase ends.
- R7: While WIP is 1, every opcode other than 0x05 is ignored and MISO stays 0.
- R8: Opcodes 0x03 (read) and 0x02 (write) take a 3-byte address, MSB first. Address bits above the array size are dropped. The address increments for each further data byte and wraps from the last cell to cell 0.
- R9: Block-protect code 01 makes the top quarter of the array read-only to memory writes, code 10 the top half and code 11 the whole array. Writes to unprotected cells still land.
- R10: When the protect-enable bit is 1 and wp_n is low, opcode 0x01 is rejected: status and WEL keep their values and no busy phase starts.
- R11: Opcode 0x9F returns the 4-byte DEVICE_ID, MSB first. Opcode 0x83 returns DEVICE_ID followed by the 4-byte UNIQUE_ID. Any byte beyond those reads 0x00.
- R12: If chip select rises before all 8 opcode bits have arrived, nothing is executed.
- R13: Opcodes 0xB9 and 0xE2 put the block to sleep at the end of their selection. The next selection only wakes it and is ignored, with MISO at 0. The selection after that executes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect input, active low, quasi-static |
| miso | output | 1 | Serial data to the host |

## Verification
The bench times the busy phase from both ends. A status poll part-way through the phase must still show WIP, and one taken after WRITE_CYCLES must show it clear with WEL dropped. A timer that is too short fails the first poll; a latch left set fails the second. It sends a status write and a memory read during the busy phase. A design that lets either through would alter the spare field or return real data. It also checks the wrap from the last cell and protected writes under each block-protect code; a wrong boundary shows up as an overwritten cell. A truncated opcode must leave WEL unchanged, and the selection after a sleep opcode must be ignored. A design that treats either one as a command changes WEL or answers a poll it should have dropped.

// File: rtl/spi_nvm_pkg.sv
// Package: opcodes, command phases and the block-protect decode shared by
// the controller. Assumes an array of at least four cells.
package spi_nvm_pkg;

    localparam logic [7:0] OP_WEL_SET = 8'h06;
    localparam logic [7:0] OP_WEL_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;
    localparam logic [7:0] OP_ID_RD   = 8'h9F;
    localparam logic [7:0] OP_IDU_RD  = 8'h83;
    localparam logic [7:0] OP_SLEEP   = 8'hB9;
    localparam logic [7:0] OP_PWR_DN  = 8'hE2;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_SRDATA,
        PH_STAT,
        PH_IDOUT,
        PH_IGNORE
    } phase_e;

    // True when a cell whose two top address bits are top2 is write-locked
    function automatic logic blk_locked(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_link.sv
// SPI mode 0 serial engine. Synchronises the pins into clk, assembles bytes
// on SCK rising edges and shifts tx_byte out MSB first after falling edges.
// Assumes SCK runs slower than a quarter of clk so every edge is seen.
module spi_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       cs_fall,
    output logic       cs_rise
);
    logic [2:0] sck_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       cs_low;
    logic       sck_rise;
    logic       sck_fall;

    assign cs_low   = !cs_q[1];
    assign sck_rise = sck_q[1] && !sck_q[2];
    assign sck_fall = !sck_q[1] && sck_q[2];
    assign cs_fall  = !cs_q[1] && cs_q[2];
    assign cs_rise  = cs_q[1] && !cs_q[2];
    assign miso     = tx_sr[7];

    // Two-flop synchronisers plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 3'b000;
            cs_q   <= 3'b111;
            mosi_q <= 2'b00;
        end else begin
            sck_q  <= {sck_q[1:0], sck};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    // Receive shifter: counts bits and flags each completed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= 3'd0;
            rx_sr      <= 7'd0;
            byte_valid <= 1'b0;
            rx_byte    <= 8'd0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_low) begin
                bit_cnt <= 3'd0;
                rx_sr   <= 7'd0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sr   <= {rx_sr[5:0], mosi_q[1]};
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {rx_sr, mosi_q[1]};
                end
            end
        end
    end

    // Transmit shifter: loads the next byte at a byte boundary, else shifts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= 8'd0;
        end else if (!cs_low) begin
            tx_sr <= 8'd0;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) tx_sr <= tx_byte;
            else                 tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

    // R12: a byte can only complete while chip select has been low
    a_r12_no_byte_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_low && !$past(cs_low)) |-> !byte_valid);

endmodule

// File: rtl/status_unit.sv
// Status byte and write-busy timer. Holds protect enable, the volatile spare
// field, block-protect code and WEL, and counts the busy phase. Assumes
// wel_set, wel_clr and start only arrive at command ends.
module status_unit #(
    parameter int WRITE_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       start,
    output logic [7:0] status,
    output logic       wip,
    output logic       wel,
    output logic       wpen,
    output logic [1:0] bp
);
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    logic [2:0]    spare;
    logic [TW-1:0] timer;
    logic          phase_end;

    assign wip       = (timer != '0);
    assign phase_end = (timer == TW'(1)) && !start;
    assign status    = {wpen, spare, bp, wel, wip};

    // Writable status fields, loaded from the status-write data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpen  <= 1'b0;
            spare <= 3'b000;
            bp    <= 2'b00;
        end else if (wr_en) begin
            wpen  <= wr_data[7];
            spare <= wr_data[6:4];
            bp    <= wr_data[3:2];
        end
    end

    // Busy-phase down-counter
    always_ff @(posedge clk) begin
        if (!rst_n)              timer <= '0;
        else if (start)          timer <= TW'(WRITE_CYCLES);
        else if (timer != '0)    timer <= timer - TW'(1);
    end

    // Write enable latch: cleared by disable or the end of a busy phase
    always_ff @(posedge clk) begin
        if (!rst_n)                     wel <= 1'b0;
        else if (wel_clr || phase_end)  wel <= 1'b0;
        else if (wel_set)               wel <= 1'b1;
    end

    // R6: WEL is already low in the cycle the busy flag drops
    a_r6_wel_low_at_phase_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    // R6: a started phase reports busy on the next cycle
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> wip);
    // R4: a status write never moves the latch
    a_r4_write_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(wel));

endmodule

// File: rtl/byte_store.sv
// Register array that stands in for the storage cells. One write port and
// one combinational read port. Contents are not reset.
module byte_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Cell update on write strobe
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_nvm_ctrl.sv
// SPI memory command and status controller. Decodes one opcode per
// selection, sequences address and data bytes, guards writes with WEL,
// block protect and wp_n, and handles sleep. Assumes ADDR_W between 2 and 24
// and wp_n held steady around selections.
module spi_nvm_ctrl
    import spi_nvm_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          WRITE_CYCLES = 2000,
    parameter logic [31:0] DEVICE_ID    = 32'h0A5C_3301,
    parameter logic [31:0] UNIQUE_ID    = 32'h1234_5678
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    localparam logic [63:0] ID_WORD = {DEVICE_ID, UNIQUE_ID};

    logic              byte_valid, cs_fall, cs_rise;
    logic [7:0]        rx_byte, tx_next, status;
    logic              wip, wel, wpen;
    logic [1:0]        bp;
    logic              sr_wr_en, wel_set, wel_clr, wr_start;
    logic [7:0]        sr_wd;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa, addr;
    logic [7:0]        mem_wd, mem_rdata;

    phase_e      phase;
    logic [15:0] addr_sh;
    logic [1:0]  acnt;
    logic        is_write, fetch;
    logic [3:0]  idx, id_len;
    logic        pend_wr, pend_set, pend_clr, pend_sleep;
    logic        asleep, frame_skip;

    spi_link u_link (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_next), .miso(miso), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    status_unit #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(sr_wr_en), .wr_data(sr_wd),
        .wel_set(wel_set), .wel_clr(wel_clr), .start(wr_start),
        .status(status), .wip(wip), .wel(wel), .wpen(wpen), .bp(bp)
    );

    byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .raddr(addr), .rdata(mem_rdata)
    );

    // Pick identification byte i of a response that is len bytes long
    function automatic logic [7:0] id_byte(input logic [3:0] i, input logic [3:0] len);
        if (i < len) return ID_WORD[8*(7 - int'(i[2:0])) +: 8];
        return 8'h00;
    endfunction

    // Command sequencer: opcode decode, address/data phases, end-of-frame actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_OPCODE;
            addr_sh    <= 16'd0;
            acnt       <= 2'd0;
            addr       <= '0;
            is_write   <= 1'b0;
            fetch      <= 1'b0;
            idx        <= 4'd0;
            id_len     <= 4'd0;
            pend_wr    <= 1'b0;
            pend_set   <= 1'b0;
            pend_clr   <= 1'b0;
            pend_sleep <= 1'b0;
            asleep     <= 1'b0;
            frame_skip <= 1'b0;
            tx_next    <= 8'd0;
            mem_we     <= 1'b0;
            mem_wa     <= '0;
            mem_wd     <= 8'd0;
            sr_wr_en   <= 1'b0;
            sr_wd      <= 8'd0;
            wel_set    <= 1'b0;
            wel_clr    <= 1'b0;
            wr_start   <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            sr_wr_en <= 1'b0;
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            wr_start <= 1'b0;
            if (fetch) begin
                tx_next <= mem_rdata;
                addr    <= addr + ADDR_W'(1);
                fetch   <= 1'b0;
            end
            if (cs_fall) begin
                frame_skip <= asleep;
                asleep     <= 1'b0;
            end
            if (cs_rise) begin
                wr_start   <= pend_wr;
                wel_set    <= pend_set;
                wel_clr    <= pend_clr;
                if (pend_sleep) asleep <= 1'b1;
                pend_wr    <= 1'b0;
                pend_set   <= 1'b0;
                pend_clr   <= 1'b0;
                pend_sleep <= 1'b0;
                phase      <= PH_OPCODE;
                tx_next    <= 8'd0;
                acnt       <= 2'd0;
                fetch      <= 1'b0;
            end else if (byte_valid) begin
                case (phase)
                    PH_OPCODE: begin
                        if (frame_skip || (wip && rx_byte != OP_STAT_RD)) begin
                            phase <= PH_IGNORE;
                        end else begin
                            case (rx_byte)
                                OP_STAT_RD: begin
                                    tx_next <= status;
                                    phase   <= PH_STAT;
                                end
                                OP_STAT_WR: begin
                                    if (wel && !(wpen && !wp_n)) phase <= PH_SRDATA;
                                    else                         phase <= PH_IGNORE;
                                end
                                OP_MEM_RD: begin
                                    is_write <= 1'b0;
                                    acnt     <= 2'd0;
                                    phase    <= PH_ADDR;
                                end
                                OP_MEM_WR: begin
                                    is_write <= 1'b1;
                                    acnt     <= 2'd0;
                                    phase    <= wel ? PH_ADDR : PH_IGNORE;
                                end
                                OP_ID_RD: begin
                                    tx_next <= id_byte(4'd0, 4'd4);
                                    idx     <= 4'd1;
                                    id_len  <= 4'd4;
                                    phase   <= PH_IDOUT;
                                end
                                OP_IDU_RD: begin
                                    tx_next <= id_byte(4'd0, 4'd8);
                                    idx     <= 4'd1;
                                    id_len  <= 4'd8;
                                    phase   <= PH_IDOUT;
                                end
                                OP_WEL_SET: begin
                                    pend_set <= 1'b1;
                                    phase    <= PH_IGNORE;
                                end
                                OP_WEL_CLR: begin
                                    pend_clr <= 1'b1;
                                    phase    <= PH_IGNORE;
                                end
                                OP_SLEEP, OP_PWR_DN: begin
                                    pend_sleep <= 1'b1;
                                    phase      <= PH_IGNORE;
                                end
                                default: phase <= PH_IGNORE;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        addr_sh <= {addr_sh[7:0], rx_byte};
                        acnt    <= acnt + 2'd1;
                        if (acnt == 2'd2) begin
                            addr  <= ADDR_W'({addr_sh, rx_byte});
                            phase <= is_write ? PH_WDATA : PH_RDATA;
                            fetch <= !is_write;
                        end
                    end
                    PH_RDATA: fetch <= 1'b1;
                    PH_WDATA: begin
                        if (!blk_locked(bp, addr[ADDR_W-1 -: 2])) begin
                            mem_we <= 1'b1;
                            mem_wa <= addr;
                            mem_wd <= rx_byte;
                        end
                        addr    <= addr + ADDR_W'(1);
                        pend_wr <= 1'b1;
                    end
                    PH_SRDATA: begin
                        sr_wr_en <= 1'b1;
                        sr_wd    <= rx_byte;
                        pend_wr  <= 1'b1;
                        phase    <= PH_IGNORE;
                    end
                    PH_STAT: tx_next <= status;
                    PH_IDOUT: begin
                        tx_next <= id_byte(idx, id_len);
                        if (idx != 4'd15) idx <= idx + 4'd1;
                    end
                    default: phase <= PH_IGNORE;
                endcase
            end
        end
    end

    // R9: no cell inside the protected region is ever written
    a_r9_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !blk_locked(bp, mem_wa[ADDR_W-1 -: 2]));
    // R5: memory and status writes only happen with the latch set
    a_r5_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || sr_wr_en) |-> wel);
    // R7: nothing is written and no latch is set while busy
    a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || sr_wr_en || wel_set) |-> !wip);
    // R3: the latch only changes at the end of a selection
    a_r3_wel_edge_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(wel_set));

endmodule

// File: tb/spi_nvm_ctrl_bench.sv
`timescale 1ns/1ps
module spi_nvm_ctrl_bench;
    localparam int          ADDR_W = 8;
    localparam int          WCYC   = 2000;
    localparam logic [31:0] DEV_ID = 32'hC3A1_0F42;
    localparam logic [31:0] UID    = 32'h9E07_B6D5;
    localparam int          H      = 8;

    typedef struct packed {
        logic [1:0]  bp;
        logic [23:0] addr;
        logic [7:0]  data;
        logic [7:0]  expd;
    } vec_t;

    // Protect code, address, data written, value expected on read-back (R9)
    localparam vec_t VECS [9] = '{
        '{2'b00, 24'h000010, 8'h11, 8'h11},
        '{2'b00, 24'h0000C0, 8'h22, 8'h22},
        '{2'b00, 24'h000090, 8'h33, 8'h33},
        '{2'b00, 24'h000050, 8'h44, 8'h44},
        '{2'b01, 24'h0000C0, 8'hAA, 8'h22},
        '{2'b01, 24'h000090, 8'h55, 8'h55},
        '{2'b10, 24'h000090, 8'h66, 8'h55},
        '{2'b10, 24'h000050, 8'h77, 8'h77},
        '{2'b11, 24'h000010, 8'h99, 8'h11}
    };

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    int   checks = 0, errors = 0, cyc = 0;

    always #5 clk = ~clk;

    spi_nvm_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WCYC), .DEVICE_ID(DEV_ID), .UNIQUE_ID(UID))
        u_spi_nvm_ctrl (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                        .mosi(mosi), .wp_n(wp_n), .miso(miso));

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks = checks + 1;
        if (act !== expv) begin
            errors = errors + 1;
            $display("FAIL %s actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic sel_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    // Shift n bits of tx out MSB first, capture MISO at each rising edge
    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(H);
            sck = 1'b1;
            rx[i] = miso;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] r;
        sel_begin(); xb(op, r); sel_end();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        sel_begin(); xb(8'h05, r); xb(8'h00, s); sel_end();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rd_status(s);
            if (!s[0]) break;
        end
    endtask

    task automatic wr_status_frame(input logic [7:0] d);
        logic [7:0] r;
        sel_begin(); xb(8'h01, r); xb(d, r); sel_end();
    endtask

    task automatic mem_wr(input logic [23:0] a, input logic [7:0] d);
        logic [7:0] r;
        sel_begin(); xb(8'h02, r);
        xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); xb(d, r);
        sel_end();
    endtask

    task automatic mem_rd(input logic [23:0] a, output logic [7:0] d);
        logic [7:0] r;
        sel_begin(); xb(8'h03, r);
        xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); xb(8'h00, d);
        sel_end();
    endtask

    initial begin
        logic [7:0] s, r, d;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);

        // R2: reset state
        check("R2 miso idle", {7'd0, miso}, 8'h00);
        rd_status(s);
        check("R2 status after reset", s, 8'h00);

        // R3: latch set and clear
        op_only(8'h06);
        rd_status(s);
        check("R3 WEL set", s, 8'h02);
        op_only(8'h04);
        rd_status(s);
        check("R3 WEL cleared", s, 8'h00);

        // R4/R6: status write loads bits 7:2 only, latch drops at phase end
        op_only(8'h06);
        wr_status_frame(8'hF3);
        wait_idle();
        rd_status(s);
        check("R4 status write bits 7:2", s, 8'hF0);

        // R1: status repeated on further bytes in one selection
        sel_begin(); xb(8'h05, r); xb(8'h00, s); xb(8'h00, d); sel_end();
        check("R1 status byte", s, 8'hF0);
        check("R1 status repeated", d, 8'hF0);

        // R10: protect enable with wp_n low rejects status write
        wp_n = 1'b0;
        op_only(8'h06);
        wr_status_frame(8'h00);
        rd_status(s);
        check("R10 status write rejected", s, 8'hF2);
        wp_n = 1'b1;
        wr_status_frame(8'h00);
        wait_idle();
        rd_status(s);
        check("R10 status write accepted with wp_n high", s, 8'h00);

        // R5: writes without the latch do nothing
        op_only(8'h06);
        mem_wr(24'h000020, 8'h5A);
        wait_idle();
        mem_wr(24'h000020, 8'hEE);
        rd_status(s);
        check("R5 no busy phase without WEL", s, 8'h00);
        mem_rd(24'h000020, d);
        check("R5 cell unchanged", d, 8'h5A);
        wr_status_frame(8'h70);
        rd_status(s);
        check("R5 status write without WEL", s, 8'h00);

        // R6: busy phase length and latch clear
        op_only(8'h06);
        mem_wr(24'h000030, 8'h3C);
        rd_status(s);
        check("R6 busy right after write", s, 8'h03);
        wait_clk(WCYC - 700);
        rd_status(s);
        check("R6 still busy late in phase", s, 8'h03);
        wait_clk(700);
        rd_status(s);
        check("R6 idle and WEL cleared after phase", s, 8'h00);

        // R7: only status reads run while busy
        op_only(8'h06);
        mem_wr(24'h000031, 8'h7E);
        wr_status_frame(8'h70);
        mem_rd(24'h000020, d);
        check("R7 read ignored while busy", d, 8'h00);
        wait_idle();
        rd_status(s);
        check("R7 status write ignored while busy", s, 8'h00);
        mem_rd(24'h000031, d);
        check("R7 write before busy landed", d, 8'h7E);

        // R8: burst write across the top of the array wraps to cell 0
        op_only(8'h06);
        sel_begin(); xb(8'h02, r); xb(8'h00, r); xb(8'h00, r); xb(8'hFE, r);
        xb(8'hA1, r); xb(8'hA2, r); xb(8'hA3, r); sel_end();
        wait_idle();
        sel_begin(); xb(8'h03, r); xb(8'h00, r); xb(8'h00, r); xb(8'hFE, r);
        xb(8'h00, s); xb(8'h00, d); xb(8'h00, r); sel_end();
        check("R8 burst byte 0", s, 8'hA1);
        check("R8 burst byte 1", d, 8'hA2);
        check("R8 burst wrapped byte", r, 8'hA3);
        mem_rd(24'h7F0000, d);
        check("R8 upper address bits dropped", d, 8'hA3);

        // R11: identification reads
        sel_begin(); xb(8'h9F, r);
        for (int b = 0; b < 5; b++) begin
            xb(8'h00, d);
            check("R11 device id byte", d, (b < 4) ? DEV_ID[8*(3-b) +: 8] : 8'h00);
        end
        sel_end();
        sel_begin(); xb(8'h83, r);
        for (int b = 0; b < 9; b++) begin
            xb(8'h00, d);
            check("R11 id plus unique id byte", d,
                  (b < 8) ? ((b < 4) ? DEV_ID[8*(3-b) +: 8] : UID[8*(7-b) +: 8]) : 8'h00);
        end
        sel_end();

        // R12: truncated opcode is dropped
        sel_begin(); xbits(8'h06, 5, r); sel_end();
        rd_status(s);
        check("R12 partial opcode ignored", s, 8'h00);
        sel_begin(); xbits(8'h06, 7, r); sel_end();
        rd_status(s);
        check("R12 seven-bit opcode ignored", s, 8'h00);

        // R13: sleep and power-down swallow the waking selection
        op_only(8'hB9);
        op_only(8'h06);
        rd_status(s);
        check("R13 wake selection ignored", s, 8'h00);
        op_only(8'h06);
        rd_status(s);
        check("R13 normal after wake", s, 8'h02);
        op_only(8'hE2);
        rd_status(s);
        check("R13 power-down wake poll ignored", s, 8'h00);
        rd_status(s);
        check("R13 status after power-down wake", s, 8'h02);
        op_only(8'h04);

        // R9: vector table across block-protect codes
        for (int v = 0; v < 9; v++) begin
            op_only(8'h06);
            wr_status_frame({4'b0000, VECS[v].bp, 2'b00});
            wait_idle();
            op_only(8'h06);
            mem_wr(VECS[v].addr, VECS[v].data);
            wait_idle();
            mem_rd(VECS[v].addr, d);
            check("R9 protected region read-back", d, VECS[v].expd);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule